// File: doc/BRIEF.md
# Checkpointed Dual-Copy Register File

This block is the register file of one strand whose core speculates past long-latency events. Each architectural register has two storage slots and a one-bit selector that says which slot is the architectural one. The other slot is the shadow. When a control unit raises a checkpoint command, all later writes go to the shadow slots. A successful episode ends with a join, which makes the shadow values architectural in one cycle by flipping only the selector bits of the registers that were written. A failed episode discards every shadow value, and the state from the moment of the checkpoint comes back. No data moves in either case.

Writes can be re-executed out of program order, so each write carries an age tag, where a larger tag means a younger instruction. For every register the file records the tag of the last accepted shadow writer. An older write that arrives after a younger one has already written that register in the same episode is refused. A separate bypass copy of every register takes every write, refused or not, so that operand forwarding always sees the most recent value. The file has two read ports. Each port returns the visible register value and the bypass value at the same address.

Top module: `ckpt_regfile`

## Requirements
- R1: After reset, both read ports and both bypass outputs return zero for every register, and `specActive` is 0.
- R2: Outside speculation, a write updates the architectural value. The value is visible on the read ports in the cycle after the write edge.
- R3: A checkpoint command with `specActive` at 0 sets `specActive` in the next cycle. A checkpoint command while `specActive` is 1 has no effect.
- R4: During speculation, an accepted write goes to the shadow slot. A read returns the shadow value of a register written in this episode and the architectural value of any other register.
- R5: A join ends the episode in one cycle. Every register written in the episode takes its shadow value as its architectural value, every other register keeps its value, and `specActive` returns to 0.
- R6: A fail ends the episode in one cycle. Every register reads back the value it held when the checkpoint was taken, and `specActive` returns to 0.
- R7: During speculation, a write whose age tag is numerically less than the tag of that register's last accepted writer in the episode is dropped. A tag that is equal or greater is accepted and becomes the new recorded tag.
- R8: The bypass value of a register is updated by every write: writes outside speculation, accepted shadow writes, writes refused by the age rule, and writes in a fail cycle.
- R9: A write and a join in the same cycle are resolved as the write first, then the join, so an accepted write is part of the committed state.
- R10: A write in the same cycle as a fail is not kept. When join and fail are raised together, the fail wins.
- R11: Join and fail commands while `specActive` is 0 have no effect on the register values or on `specActive`.
- R12: A write in the same cycle as a checkpoint, with `specActive` at 0, lands in the architectural state and survives a later fail.
- R13: Recorded age tags and written marks are cleared when an episode ends. In the next episode, the first write to a register is accepted whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdCkpt | input | 1 | Take a checkpoint and start speculating |
| cmdJoin | input | 1 | Commit the current episode |
| cmdFail | input | 1 | Abandon the current episode |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write register index |
| wrData | input | DATA_W | Write value |
| wrAge | input | AGE_W | Age tag of the writer, larger is younger |
| rdAddrA | input | ADDR_W | Read port A index |
| rdDataA | output | DATA_W | Visible value at port A |
| fwdDataA | output | DATA_W | Bypass value at port A |
| rdAddrB | input | ADDR_W | Read port B index |
| rdDataB | output | DATA_W | Visible value at port B |
| fwdDataB | output | DATA_W | Bypass value at port B |
| specActive | output | 1 | High while an episode is open |

## Verification
The bench builds the file with 8 registers, 16-bit data and 4-bit age tags. With few registers, random writes hit the same register again and again within one episode. With a narrow tag, older and younger writers collide often, so the age refusal, the equal-tag case and the write-plus-join and write-plus-fail collisions all occur many times in the random phase, in addition to the directed sequences for each requirement.

// File: rtl/ckrf_pkg.sv
package ckrf_pkg;

  // Strobes from the episode controller to the storage datapath
  typedef struct packed {
    logic specMode;  // an episode is open this cycle
    logic doJoin;    // commit at this edge
    logic doFail;    // abandon at this edge
  } ckrfStrobes_t;

endpackage

// File: rtl/ckrf_ctrl.sv
module ckrf_ctrl
  import ckrf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdCkpt,
  input  logic         cmdJoin,
  input  logic         cmdFail,
  output ckrfStrobes_t strobes,
  output logic         specActive
);

  logic openNow;
  logic closeNow;

  always_comb begin
    strobes.specMode = specActive;
    strobes.doFail   = specActive & cmdFail;
    strobes.doJoin   = specActive & cmdJoin & ~cmdFail;
    openNow          = ~specActive & cmdCkpt;
    closeNow         = strobes.doFail | strobes.doJoin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         specActive <= 1'b0;
    else if (closeNow) specActive <= 1'b0;
    else if (openNow)  specActive <= 1'b1;
  end

  // R3
  ckpt_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!specActive && cmdCkpt) |=> specActive);

  // R3
  ckpt_nested_chk: assert property (@(posedge clk) disable iff (!rstN)
    (specActive && cmdCkpt && !cmdJoin && !cmdFail) |=> specActive);

  // R11
  idle_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!specActive && !cmdCkpt && (cmdJoin || cmdFail)) |=> !specActive);

  // R5
  join_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (specActive && cmdJoin) |=> !specActive);

endmodule

// File: rtl/ckrf_entry.sv
module ckrf_entry
  import ckrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AGE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ckrfStrobes_t      strobes,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AGE_W-1:0]  wrAge,
  output logic [DATA_W-1:0] readVal
);

  logic [DATA_W-1:0] copyMem [2];
  logic              archPtr;
  logic              specFlag;
  logic [AGE_W-1:0]  lastAge;
  logic [DATA_W-1:0] archVal;
  logic [DATA_W-1:0] shadowVal;
  logic              ageOk;
  logic              accept;
  logic              archWr;

  always_comb begin
    archVal   = copyMem[archPtr];
    shadowVal = copyMem[~archPtr];
    ageOk     = ~specFlag | (wrAge >= lastAge);
    accept    = wrSel & strobes.specMode & ageOk;
    archWr    = wrSel & ~strobes.specMode;
    readVal   = (strobes.specMode & specFlag) ? shadowVal : archVal;
  end

  // Storage slots
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) copyMem[i] <= '0;
    end else if (archWr) begin
      copyMem[archPtr] <= wrData;
    end else if (accept && !strobes.doFail) begin
      copyMem[~archPtr] <= wrData;
    end
  end

  // Selector, written mark and age tag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      archPtr  <= 1'b0;
      specFlag <= 1'b0;
      lastAge  <= '0;
    end else if (strobes.doFail) begin
      specFlag <= 1'b0;
      lastAge  <= '0;
    end else if (strobes.doJoin) begin
      archPtr  <= archPtr ^ (specFlag | accept);
      specFlag <= 1'b0;
      lastAge  <= '0;
    end else if (accept) begin
      specFlag <= 1'b1;
      lastAge  <= wrAge;
    end
  end

  // R7
  age_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrSel && strobes.specMode && specFlag && (wrAge < lastAge)
     && !strobes.doJoin && !strobes.doFail)
    |=> ($stable(shadowVal) && specFlag && $stable(lastAge)));

  // R5
  join_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doJoin && !specFlag && !wrSel) |=> $stable(archPtr));

  // R6
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doFail |=> (!specFlag && $stable(archPtr)));

  // R2
  arch_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    archWr |=> (archVal == $past(wrData)));

endmodule

// File: rtl/ckrf_datapath.sv
module ckrf_datapath
  import ckrf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int AGE_W    = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ckrfStrobes_t      strobes,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AGE_W-1:0]  wrAge,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] fwdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] fwdDataB
);

  logic [DATA_W-1:0] entryVal [NUM_REGS];
  logic [DATA_W-1:0] fwdMem   [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gEntry
    logic sel;
    assign sel = wrEn && (wrAddr == ADDR_W'(g));
    ckrf_entry #(
      .DATA_W(DATA_W),
      .AGE_W (AGE_W)
    ) uEntry (
      .clk    (clk),
      .rstN   (rstN),
      .strobes(strobes),
      .wrSel  (sel),
      .wrData (wrData),
      .wrAge  (wrAge),
      .readVal(entryVal[g])
    );
  end

  // Bypass copy: takes every write unconditionally
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) fwdMem[i] <= '0;
    end else if (wrEn) begin
      fwdMem[wrAddr] <= wrData;
    end
  end

  always_comb begin
    rdDataA  = entryVal[rdAddrA];
    rdDataB  = entryVal[rdAddrB];
    fwdDataA = fwdMem[rdAddrA];
    fwdDataB = fwdMem[rdAddrB];
  end

  // R8
  fwd_always_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (fwdMem[$past(wrAddr)] == $past(wrData)));

endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
  import ckrf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int AGE_W    = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdCkpt,
  input  logic              cmdJoin,
  input  logic              cmdFail,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AGE_W-1:0]  wrAge,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] fwdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] fwdDataB,
  output logic              specActive
);

  ckrfStrobes_t strobes;

  ckrf_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdCkpt   (cmdCkpt),
    .cmdJoin   (cmdJoin),
    .cmdFail   (cmdFail),
    .strobes   (strobes),
    .specActive(specActive)
  );

  ckrf_datapath #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .AGE_W   (AGE_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .wrAge   (wrAge),
    .rdAddrA (rdAddrA),
    .rdDataA (rdDataA),
    .fwdDataA(fwdDataA),
    .rdAddrB (rdAddrB),
    .rdDataB (rdDataB),
    .fwdDataB(fwdDataB)
  );

endmodule

// File: tb/sim_ckpt_regfile.sv
`timescale 1ns/1ps
module sim_ckpt_regfile;

  localparam int NR = 8;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int XW = $clog2(NR);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdCkpt = 0, cmdJoin = 0, cmdFail = 0, wrEn = 0;
  logic [XW-1:0] wrAddr = '0, rdAddrA = '0, rdAddrB = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] wrAge = '0;
  logic [DW-1:0] rdDataA, rdDataB, fwdDataA, fwdDataB;
  logic specActive;

  always #2.5 clk = ~clk;

  ckpt_regfile #(.NUM_REGS(NR), .DATA_W(DW), .AGE_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .cmdCkpt(cmdCkpt), .cmdJoin(cmdJoin), .cmdFail(cmdFail),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrAge(wrAge),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .fwdDataA(fwdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .fwdDataB(fwdDataB),
    .specActive(specActive)
  );

  // Behavioural reference: committed values, episode values, marks, tags
  logic [DW-1:0] mArch [NR];
  logic [DW-1:0] mSpec [NR];
  logic [DW-1:0] mFwd  [NR];
  bit            mWrit [NR];
  int            mAge  [NR];
  bit            mInSpec;

  int checks = 0;
  int fails = 0;
  int cycleCnt = 0;
  string curReq = "R1";

  initial begin
    for (int i = 0; i < NR; i++) begin
      mArch[i] = '0; mSpec[i] = '0; mFwd[i] = '0; mWrit[i] = 0; mAge[i] = 0;
    end
    mInSpec = 0;
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (wrEn) begin
        mFwd[wrAddr] = wrData;
        if (!mInSpec) mArch[wrAddr] = wrData;
        else if (!mWrit[wrAddr] || int'(wrAge) >= mAge[wrAddr]) begin
          mSpec[wrAddr] = wrData;
          mWrit[wrAddr] = 1;
          mAge[wrAddr]  = int'(wrAge);
        end
      end
      if (mInSpec && cmdFail) begin
        for (int i = 0; i < NR; i++) mWrit[i] = 0;
        mInSpec = 0;
      end else if (mInSpec && cmdJoin) begin
        for (int i = 0; i < NR; i++) begin
          if (mWrit[i]) mArch[i] = mSpec[i];
          mWrit[i] = 0;
        end
        mInSpec = 0;
      end else if (!mInSpec && cmdCkpt) begin
        mInSpec = 1;
      end
    end
  end

  function automatic logic [DW-1:0] visible(input int a);
    return (mInSpec && mWrit[a]) ? mSpec[a] : mArch[a];
  endfunction

  task automatic checkOne(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    checkOne("rdDataA", rdDataA, visible(int'(rdAddrA)));
    checkOne("rdDataB", rdDataB, visible(int'(rdAddrB)));
    checkOne("fwdDataA", fwdDataA, mFwd[rdAddrA]);
    checkOne("fwdDataB", fwdDataB, mFwd[rdAddrB]);
    checkOne("specActive", DW'(specActive), DW'(mInSpec));
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic cyc(input bit ck, input bit jn, input bit fl, input bit we,
                     input int a, input logic [DW-1:0] d, input int ag,
                     input int ra, input int rb);
    cmdCkpt = ck; cmdJoin = jn; cmdFail = fl; wrEn = we;
    wrAddr = XW'(a); wrData = d; wrAge = AW'(ag);
    rdAddrA = XW'(ra); rdAddrB = XW'(rb);
    tick();
    cmdCkpt = 0; cmdJoin = 0; cmdFail = 0; wrEn = 0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt >= 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycleCnt, 100000);
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    tick(); tick();
    rstN = 1'b1;
    for (int r = 0; r < NR; r++) cyc(0,0,0,0,0,'0,0,r,NR-1-r);

    // R2: plain writes
    curReq = "R2";
    cyc(0,0,0,1,1,16'hAAAA,0,1,2);
    cyc(0,0,0,1,2,16'h5555,0,1,2);

    // R3: open an episode, nested checkpoint ignored
    curReq = "R3";
    cyc(1,0,0,0,0,'0,0,1,2);
    cyc(1,0,0,0,0,'0,0,1,2);

    // R4: shadow write, untouched register shows committed value
    curReq = "R4";
    cyc(0,0,0,1,1,16'h1111,5,1,2);

    // R7: older writer refused, equal tag accepted; R8 bypass sees both
    curReq = "R7";
    cyc(0,0,0,1,1,16'h2222,3,1,2);
    curReq = "R8";
    cyc(0,0,0,0,0,'0,0,1,1);
    curReq = "R7";
    cyc(0,0,0,1,1,16'h3333,5,1,2);

    // R9: write together with join
    curReq = "R9";
    cyc(0,1,0,1,2,16'h7777,1,1,2);
    curReq = "R5";
    cyc(0,0,0,0,0,'0,0,1,2);

    // R13: fresh episode accepts tag 0; R6 fail restores
    curReq = "R13";
    cyc(1,0,0,0,0,'0,0,1,2);
    cyc(0,0,0,1,1,16'h4444,0,1,2);
    curReq = "R6";
    cyc(0,0,0,0,0,'0,0,1,2);
    cyc(0,0,1,0,0,'0,0,1,2);

    // R10: write in fail cycle dropped; fail wins over join
    curReq = "R10";
    cyc(1,0,0,0,0,'0,0,3,2);
    cyc(0,0,1,1,3,16'h9999,2,3,2);
    cyc(1,0,0,0,0,'0,0,3,2);
    cyc(0,0,0,1,2,16'hBEEF,2,3,2);
    cyc(0,1,1,0,0,'0,0,3,2);

    // R11: commands outside an episode
    curReq = "R11";
    cyc(0,1,0,0,0,'0,0,1,2);
    cyc(0,0,1,0,0,'0,0,1,2);

    // R12: write together with checkpoint, then fail
    curReq = "R12";
    cyc(1,0,0,1,4,16'hABCD,0,4,1);
    cyc(0,0,0,1,4,16'h0F0F,9,4,1);
    cyc(0,0,1,0,0,'0,0,4,1);
    cyc(0,0,0,0,0,'0,0,4,1);

    // Random phase covering R4 R5 R6 R7 R8 R9 R10
    curReq = "R7";
    for (int n = 0; n < 3000; n++) begin
      int p;
      p = int'($urandom_range(0, 99));
      cyc(p < 8, (p >= 8 && p < 13), (p >= 11 && p < 15),
          ($urandom_range(0, 9) < 6), int'($urandom_range(0, NR-1)),
          DW'($urandom), int'($urandom_range(0, (1 << AW) - 1)),
          int'($urandom_range(0, NR-1)), int'($urandom_range(0, NR-1)));
    end

    finishRun();
  end

endmodule